// File: doc/BRIEF.md
# Mode-0 Parallel Port with Output Buffer Control

This block provides 24 general-purpose I/O lines behind a byte-wide register bus with four addresses: three data ports and one control address. Ports A and B are 8-bit direction groups. Port C has two 4-bit groups, its lower and upper nibbles, and each nibble has its own direction. Output data is held in latches. Input data is read live from the pins.

A buffer-enable controller sits beside the port logic and gates the external output drivers. A control write with bit 7 set is a mode set. It loads all four directions, clears every output latch and tristates the drivers. A control write with bit 7 clear goes only to the buffer controller. This allows a glitch-free bring-up:
1. Set the mode.
2. Preload the port data while the drivers are still off.
3. Enable the drivers.

A static strap input can instead keep the drivers enabled at all times. The pins appear as separate input, output and output-enable vectors. Line numbering on these vectors is port A on [7:0], port B on [15:8], port C lower nibble on [19:16] and port C upper nibble on [23:20].

Top module: `ppio_mode0`

## Requirements
- R1: After a synchronous reset, every group is an input, so `pin_oe` is all zero, and every output latch, and with it `pin_out`, is zero.
- R2: A write to address 3 with bit 7 set loads the group directions, where a 1 means input: bit 4 sets port A, bit 1 sets port B, bit 0 sets the port C lower nibble and bit 3 sets the port C upper nibble. The value 0x89 makes ports A and B outputs and both port C nibbles inputs.
- R3: A mode-set write clears all 24 output latch bits to zero, and `pin_out` shows this from the next cycle.
- R4: When `strap_prog` is 1, a mode-set write disables the drivers, so `pin_oe` is all zero from the next cycle.
- R5: A write to address 3 with bit 7 clear sets the driver enable to bit 0 of the written byte. Such a write leaves the directions and the latches unchanged, so 0x09 enables the drivers and 0x00 disables them.
- R6: A write to a data port (address 0 for A, 1 for B, 2 for C) loads that port's latches whatever the directions and the driver state are. `pin_out` shows the latches from the next cycle, so a value preloaded while the drivers are off is driven once they are enabled.
- R7: `pin_oe` bit n is 1 exactly when the group holding line n is an output and the drivers are enabled.
- R8: A read (`bus_rd` = 1) of a data port returns, one cycle later on `rd_data`, the latch value for output groups and the pin values sampled at the read edge for input groups. This selection is made per nibble on port C.
- R9: A read of address 3 returns 0xFF.
- R10: When `strap_prog` is 0, the drivers count as enabled at all times, and writes to address 3 with bit 7 clear have no effect on `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 = A, 1 = B, 2 = C, 3 = control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; `rd_data` updates on the next cycle |
| rd_data | output | 8 | Registered read data |
| strap_prog | input | 1 | Static strap: 1 = drivers under program control, 0 = always enabled |
| pin_in | input | 24 | Pin input levels |
| pin_out | output | 24 | Output latch values toward the drivers |
| pin_oe | output | 24 | Per-line driver enable |

## Verification
The assertions check the following on every cycle:
- reset leaves the lines quiet;
- a mode set zeroes the latches and, under program control, tristates the drivers;
- a bit-7-clear control write leaves the latches untouched;
- a control read returns 0xFF;
- with the strap set to always-enabled, a bit-7-clear control write cannot move the enables.

The bench scenarios are needed for the rest:
- the exact direction encoding of each mode word;
- preloaded data surfacing after a late enable;
- nibble-wise mixing of latch and pin values on port C reads;
- live pin sampling on input groups.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int GROUPS  = 4;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] ADR_A   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_B   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_C   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CTL = 2'd3;
  localparam int MODE_FLAG_BIT = 7;
  localparam int EN_BIT        = 0;

  // Direction bit in a mode-set word for group g (A, B, C low, C high).
  function automatic int dir_bit(input int g);
    case (g)
      0:       return 4;
      1:       return 1;
      2:       return 0;
      default: return 3;
    endcase
  endfunction

  // Bus address that writes group g.
  function automatic logic [ADDR_W-1:0] grp_addr(input int g);
    case (g)
      0:       return ADR_A;
      1:       return ADR_B;
      default: return ADR_C;
    endcase
  endfunction
endpackage

// File: rtl/ppio_group.sv
module ppio_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_set,
  input  logic         mode_in_bit,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_in,
  output logic         is_output,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] rd_val
);
  logic dir_in_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_in_q <= 1'b1;
      latch_q  <= '0;
    end else if (mode_set) begin
      dir_in_q <= mode_in_bit;
      latch_q  <= '0;
    end else if (wr_en) begin
      latch_q  <= wr_data;
    end
  end

  assign is_output = ~dir_in_q;
  assign rd_val    = dir_in_q ? pin_in : latch_q;
endmodule

// File: rtl/ppio_bufctl.sv
module ppio_bufctl (
  input  logic clk,
  input  logic rst,
  input  logic prog_ctl,
  input  logic mode_set,
  input  logic low_wr,
  input  logic low_bit,
  output logic drv_en
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)           en_q <= 1'b0;
    else if (mode_set) en_q <= 1'b0;
    else if (low_wr)   en_q <= low_bit;
  end

  assign drv_en = prog_ctl ? en_q : 1'b1;
endmodule

// File: rtl/ppio_mode0.sv
module ppio_mode0 #(
  parameter int PORT_W = 8,
  parameter int NIB_W  = PORT_W / 2,
  parameter int LINES  = 2 * PORT_W + 2 * NIB_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ppio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      bus_wr,
  input  logic [PORT_W-1:0]         bus_wdata,
  input  logic                      bus_rd,
  output logic [PORT_W-1:0]         rd_data,
  input  logic                      strap_prog,
  input  logic [LINES-1:0]          pin_in,
  output logic [LINES-1:0]          pin_out,
  output logic [LINES-1:0]          pin_oe
);
  import ppio_pkg::*;

  localparam int C_LO = 2 * PORT_W;

  logic             ctl_wr, mode_set, low_wr, drv_en;
  logic [LINES-1:0] rd_all;

  assign ctl_wr   = bus_wr && (bus_addr == ADR_CTL);
  assign mode_set = ctl_wr &&  bus_wdata[MODE_FLAG_BIT];
  assign low_wr   = ctl_wr && !bus_wdata[MODE_FLAG_BIT];

  ppio_bufctl u_buf (
    .clk     (clk),
    .rst     (rst),
    .prog_ctl(strap_prog),
    .mode_set(mode_set),
    .low_wr  (low_wr),
    .low_bit (bus_wdata[EN_BIT]),
    .drv_en  (drv_en)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int W    = (g < 2) ? PORT_W : NIB_W;
    localparam int LO   = (g == 0) ? 0 : (g == 1) ? PORT_W :
                          (g == 2) ? C_LO : C_LO + NIB_W;
    localparam int WOFF = (g == 3) ? NIB_W : 0;
    logic is_out;

    ppio_group #(.W(W)) u_grp (
      .clk        (clk),
      .rst        (rst),
      .mode_set   (mode_set),
      .mode_in_bit(bus_wdata[dir_bit(g)]),
      .wr_en      (bus_wr && (bus_addr == grp_addr(g))),
      .wr_data    (bus_wdata[WOFF +: W]),
      .pin_in     (pin_in[LO +: W]),
      .is_output  (is_out),
      .latch_q    (pin_out[LO +: W]),
      .rd_val     (rd_all[LO +: W])
    );

    assign pin_oe[LO +: W] = {W{is_out & drv_en}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADR_A:   rd_data <= rd_all[0 +: PORT_W];
        ADR_B:   rd_data <= rd_all[PORT_W +: PORT_W];
        ADR_C:   rd_data <= rd_all[C_LO +: PORT_W];
        default: rd_data <= '1;
      endcase
    end
  end
endmodule

// File: rtl/ppio_mode0_chk.sv
module ppio_mode0_chk #(
  parameter int PORT_W = 8,
  parameter int NIB_W  = PORT_W / 2,
  parameter int LINES  = 2 * PORT_W + 2 * NIB_W
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ppio_pkg::ADDR_W-1:0] bus_addr,
  input logic                      bus_wr,
  input logic [PORT_W-1:0]         bus_wdata,
  input logic                      bus_rd,
  input logic [PORT_W-1:0]         rd_data,
  input logic                      strap_prog,
  input logic [LINES-1:0]          pin_in,
  input logic [LINES-1:0]          pin_out,
  input logic [LINES-1:0]          pin_oe
);
  logic ctl_w;
  assign ctl_w = bus_wr && (bus_addr == ppio_pkg::ADR_CTL);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0));

  a_r3_mode_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && bus_wdata[7]) |=> (pin_out == '0));

  a_r4_mode_tristates: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && bus_wdata[7] && strap_prog) |=> (pin_oe == '0));

  a_r5_low_ctl_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && !bus_wdata[7]) |=> $stable(pin_out));

  a_r9_ctl_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ppio_pkg::ADR_CTL) |=> (rd_data == '1));

  a_r10_strap_ignores_low: assert property (@(posedge clk) disable iff (rst)
    (ctl_w && !bus_wdata[7] && !strap_prog && $stable(strap_prog)) |=> $stable(pin_oe));
endmodule

bind ppio_mode0 ppio_mode0_chk #(.PORT_W(PORT_W), .NIB_W(NIB_W), .LINES(LINES)) u_chk (.*);

// File: tb/tb_ppio_mode0.sv
module tb_ppio_mode0;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  rd_data;
  logic        strap_prog = 1;
  logic [23:0] pin_in = 0, pin_out, pin_oe;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  bit        m_in[4];
  bit [7:0]  m_a, m_b, m_c;
  bit        m_en;
  bit [7:0]  m_rd;

  ppio_mode0 dut (.*);

  always #2 clk = ~clk;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic bit [23:0] exp_oe();
    bit drv = strap_prog ? m_en : 1'b1;
    bit [23:0] o;
    o[7:0]   = {8{!m_in[0] && drv}};
    o[15:8]  = {8{!m_in[1] && drv}};
    o[19:16] = {4{!m_in[2] && drv}};
    o[23:20] = {4{!m_in[3] && drv}};
    return o;
  endfunction

  // model update at the clock edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_in = '{1, 1, 1, 1}; m_a = 0; m_b = 0; m_c = 0; m_en = 0; m_rd = 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          0: m_rd = m_in[0] ? pin_in[7:0] : m_a;
          1: m_rd = m_in[1] ? pin_in[15:8] : m_b;
          2: m_rd = {m_in[3] ? pin_in[23:20] : m_c[7:4],
                     m_in[2] ? pin_in[19:16] : m_c[3:0]};
          default: m_rd = 8'hFF;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          0: m_a = bus_wdata;
          1: m_b = bus_wdata;
          2: m_c = bus_wdata;
          default:
            if (bus_wdata[7]) begin
              m_in[0] = bus_wdata[4]; m_in[1] = bus_wdata[1];
              m_in[2] = bus_wdata[0]; m_in[3] = bus_wdata[3];
              m_a = 0; m_b = 0; m_c = 0; m_en = 0;
            end else m_en = bus_wdata[0];
        endcase
      end
    end
  end

  // compare on every cycle, away from the edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      check({tag, " pin_out"}, pin_out, {m_c, m_b, m_a});
      check({tag, " pin_oe"}, pin_oe, exp_oe());
      check({tag, " rd_data"}, rd_data, m_rd);
    end
  end

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input bit [1:0] a);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    tag = "R1"; idle(2);
    check("R1 oe after reset", pin_oe, 24'h0);

    tag = "R8"; pin_in = 24'h3C_96_A5;
    rd(0); rd(1); rd(2); idle(1);
    check("R8 live pin read C", rd_data, 8'h3C);

    tag = "R2"; wr(3, 8'h89);
    tag = "R4"; check("R4 tristated after mode set", pin_oe, 24'h0);
    tag = "R6"; wr(0, 8'h5A); wr(1, 8'hC3);
    check("R6 preload visible, not driven", pin_out[15:0], 16'hC35A);
    check("R6 still tristated", pin_oe, 24'h0);
    tag = "R5"; wr(3, 8'h09);
    check("R5 R7 enable A and B", pin_oe, 24'h00FFFF);
    tag = "R8"; pin_in = 24'h71_00_00; rd(0); idle(1);
    check("R8 output group reads latch", rd_data, 8'h5A);
    rd(2); idle(1);
    check("R8 input C reads pins", rd_data, 8'h71);
    tag = "R9"; rd(3); idle(1);
    check("R9 ctl reads FF", rd_data, 8'hFF);

    tag = "R5"; wr(3, 8'h00);
    check("R5 disable keeps latch", pin_out[15:0], 16'hC35A);
    check("R5 disabled", pin_oe, 24'h0);
    wr(3, 8'h01);

    tag = "R3"; wr(3, 8'h80);
    check("R3 latches cleared", pin_out, 24'h0);
    tag = "R6"; wr(2, 8'hA5); wr(3, 8'h01);
    check("R7 all outputs", pin_oe, 24'hFFFFFF);
    tag = "R2"; wr(3, 8'h92); wr(3, 8'h01);
    check("R2 only C driven for 0x92", pin_oe, 24'hFF0000);

    tag = "R8"; wr(3, 8'h88); wr(2, 8'h6E); wr(3, 8'h01);
    pin_in = 24'h90_00_00; rd(2); idle(1);
    check("R8 C split read", rd_data, 8'h9E);
    check("R2 C upper in only", pin_oe, 24'h0FFFFF);

    tag = "R10"; strap_prog = 0; idle(1);
    wr(3, 8'h89);
    check("R10 always enabled after mode set", pin_oe, 24'h00FFFF);
    wr(3, 8'h00);
    check("R10 low ctl ignored", pin_oe, 24'h00FFFF);
    idle(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule